// File: doc/BRIEF.md
# In-Order Completion Reorder Buffer

This block is the completion queue of an out-of-order core. Dispatch places up to two instructions per clock into an eight-entry circular queue. Each entry carries a tag, a branch flag and a flag saying that it already holds an exception. Execution units report finished work by entry index. The retire port hands back up to two tags per clock, oldest first. An entry can only leave the queue when everything older has gone, its own work is done and it holds no exception. This keeps architectural state precise.

Two events cut the queue short. A mispredicted branch, named by its entry index, removes every entry dispatched after it and keeps the branch itself. An entry that reaches the head with its exception flag set stops retirement. A two-state controller then handles it. RUN is the normal state. The transition RUN to RAISE is taken when the head entry holds an exception. RAISE lasts one clock, drives the exception pulse with the head's tag and blocks all traffic. The transition RAISE to RUN happens unconditionally and empties the queue. In every other cycle the controller stays in RUN.

Top module: `completion_rob`

## Requirements
- R1: After reset the queue is empty, no retire or exception output is active, the dispatch index reads 0, and a two-entry dispatch request is granted.
- R2: The queue holds eight entries. `disp_grant_o` is high only in RUN, only when no mispredict is accepted in the same cycle, and only when the request count (0, 1 or 2) is no larger than the number of free entries. A request count of 3 is never granted.
- R3: Granted lane 0 occupies entry `disp_idx_o` and lane 1 occupies the next entry modulo 8. `disp_idx_o` advances by the granted count.
- R4: A finished report sets the done state of the named entry only if that entry is occupied. A report naming an empty entry changes nothing.
- R5: An entry retires only when all older entries have retired, it is done and it has no exception flag. An undone head blocks every younger entry.
- R6: At most two entries retire per clock. Slot 1 retires only together with slot 0. The lane-0 tag is in the low bits of `ret_tag_o` and is the older of the two.
- R7: Retirement is shown combinationally in the cycle the condition holds. A finished report is therefore visible at the retire port one clock after it is given.
- R8: A mispredict that names an occupied entry whose branch flag is set discards all younger entries. On the next clock `disp_idx_o` is the branch index plus one. No entry younger than the branch retires in the mispredict cycle, and the branch itself stays and can retire.
- R9: A mispredict that names an empty entry, or an entry without the branch flag, is ignored.
- R10: When the head entry has its exception flag, nothing retires. On the next clock `exc_valid_o` is high for exactly one cycle with the head's tag on `exc_tag_o`, and dispatch is refused. After that the queue is empty and `disp_idx_o` equals the index of the excepting entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| disp_cnt_i | input | 2 | Number of entries requested this cycle (0..2) |
| disp_tag_i | input | 2*TAG_W | Tags, lane 0 in the low bits |
| disp_br_i | input | 2 | Branch flag per lane |
| disp_exc_i | input | 2 | Exception flag per lane |
| disp_grant_o | output | 1 | Request accepted this cycle |
| disp_idx_o | output | 3 | Entry index given to lane 0 |
| fin_valid_i | input | 1 | Finished report valid |
| fin_idx_i | input | 3 | Entry index of the finished instruction |
| mp_valid_i | input | 1 | Branch mispredict report valid |
| mp_idx_i | input | 3 | Entry index of the mispredicted branch |
| ret_valid_o | output | 2 | Retire slot valid, slot 0 in bit 0 |
| ret_tag_o | output | 2*TAG_W | Retiring tags, slot 0 in the low bits |
| exc_valid_o | output | 1 | Precise exception request pulse |
| exc_tag_o | output | TAG_W | Tag of the excepting instruction |

## Verification
On every cycle, the assertions check that the occupancy never exceeds eight and never grows by more than two. They also check that slot 1 never retires without slot 0, that an undone or empty head blocks all retirement, that the exception pulse is one cycle long, retires nothing and leaves an empty queue, and that an accepted mispredict leaves no more than the branch and the entries older than it. Which tags retire in which order, the dispatch index after a flush, and the case of reports or mispredicts that name empty or non-branch entries are checks on values rather than invariants. Only the bench's reference model, run over directed and pseudo-random traffic, can show those.

// File: rtl/rob_pkg.sv
package rob_pkg;

    // Dispatch and retire width of the queue.
    localparam int LANES = 2;

    // Completion controller states.
    typedef enum logic [0:0] {
        ST_RUN   = 1'b0,
        ST_RAISE = 1'b1
    } rob_state_e;

endpackage

// File: rtl/rob_store.sv
module rob_store #(
    parameter int DEPTH = 8,
    parameter int TAG_W = 8,
    parameter int LANES = 2,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [LANES-1:0]            wr_en,
    input  logic [LANES-1:0][IDX_W-1:0] wr_idx,
    input  logic [LANES-1:0][TAG_W-1:0] wr_tag,
    input  logic [LANES-1:0]            wr_br,
    input  logic [LANES-1:0]            wr_exc,
    input  logic                        fin_set,
    input  logic [IDX_W-1:0]            fin_idx,
    output logic [DEPTH-1:0][TAG_W-1:0] tag_arr,
    output logic [DEPTH-1:0]            br_arr,
    output logic [DEPTH-1:0]            exc_arr,
    output logic [DEPTH-1:0]            done_arr
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tag_arr  <= '0;
            br_arr   <= '0;
            exc_arr  <= '0;
            done_arr <= '0;
        end else begin
            // New entries start with their done state cleared.
            for (int l = 0; l < LANES; l++) begin
                if (wr_en[l]) begin
                    tag_arr[wr_idx[l]]  <= wr_tag[l];
                    br_arr[wr_idx[l]]   <= wr_br[l];
                    exc_arr[wr_idx[l]]  <= wr_exc[l];
                    done_arr[wr_idx[l]] <= 1'b0;
                end
            end
            // Reports only reach occupied entries, so they never meet a write.
            if (fin_set) begin
                done_arr[fin_idx] <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/rob_retire_sel.sv
module rob_retire_sel #(
    parameter int DEPTH = 8,
    parameter int LANES = 2,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int PTR_W = IDX_W + 1,
    localparam int CNT_W = $clog2(LANES + 1)
) (
    input  logic             run,
    input  logic [PTR_W-1:0] count,
    input  logic [IDX_W-1:0] head_idx,
    input  logic [DEPTH-1:0] done_arr,
    input  logic [DEPTH-1:0] exc_arr,
    input  logic             mp_hit,
    input  logic [IDX_W-1:0] mp_off,
    output logic [LANES-1:0] ret_en,
    output logic [CNT_W-1:0] nret
);

    logic [LANES-1:0] elig;

    for (genvar l = 0; l < LANES; l++) begin : g_slot
        localparam logic [PTR_W-1:0] SLOT_P = PTR_W'(l);
        localparam logic [IDX_W-1:0] SLOT_I = IDX_W'(l);
        logic [IDX_W-1:0] slot_idx;

        assign slot_idx = head_idx + SLOT_I;
        // A slot younger than an accepted mispredicted branch is being flushed.
        assign elig[l]  = run && (count > SLOT_P) && done_arr[slot_idx]
                          && !exc_arr[slot_idx] && !(mp_hit && (mp_off < SLOT_I));

        if (l == 0) begin : g_first
            assign ret_en[l] = elig[l];
        end else begin : g_chain
            assign ret_en[l] = elig[l] && ret_en[l-1];
        end
    end

    always_comb begin
        nret = '0;
        for (int l = 0; l < LANES; l++) begin
            nret = nret + CNT_W'(ret_en[l]);
        end
    end

endmodule

// File: rtl/rob_fsm.sv
module rob_fsm
    import rob_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic exc_head_i,
    output logic run_o,
    output logic raise_o
);

    rob_state_e st_q;
    rob_state_e st_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= ST_RUN;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_RUN:   if (exc_head_i) st_d = ST_RAISE;
            ST_RAISE: st_d = ST_RUN;
        endcase
    end

    always_comb begin
        run_o   = 1'b0;
        raise_o = 1'b0;
        unique case (st_q)
            ST_RUN:   run_o   = 1'b1;
            ST_RAISE: raise_o = 1'b1;
        endcase
    end

endmodule

// File: rtl/completion_rob.sv
module completion_rob #(
    parameter int DEPTH = 8,
    parameter int TAG_W = 8,
    localparam int LANES = rob_pkg::LANES,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int PTR_W = IDX_W + 1,
    localparam int CNT_W = $clog2(LANES + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [CNT_W-1:0]       disp_cnt_i,
    input  logic [LANES*TAG_W-1:0] disp_tag_i,
    input  logic [LANES-1:0]       disp_br_i,
    input  logic [LANES-1:0]       disp_exc_i,
    output logic                   disp_grant_o,
    output logic [IDX_W-1:0]       disp_idx_o,
    input  logic                   fin_valid_i,
    input  logic [IDX_W-1:0]       fin_idx_i,
    input  logic                   mp_valid_i,
    input  logic [IDX_W-1:0]       mp_idx_i,
    output logic [LANES-1:0]       ret_valid_o,
    output logic [LANES*TAG_W-1:0] ret_tag_o,
    output logic                   exc_valid_o,
    output logic [TAG_W-1:0]       exc_tag_o
);

    // Pointers carry one wrap bit above the index so full and empty differ.
    logic [PTR_W-1:0] head_q, tail_q;
    logic [PTR_W-1:0] count, free_cnt, dcnt_ext, nret_ext;
    logic [IDX_W-1:0] head_idx, tail_idx;
    logic [IDX_W-1:0] mp_off, fin_off;
    logic             mp_hit, fin_set, exc_head;
    logic             run, raise;
    logic [CNT_W-1:0] nret;
    logic [LANES-1:0] ret_en;

    logic [LANES-1:0]            wr_en;
    logic [LANES-1:0][IDX_W-1:0] wr_idx;
    logic [LANES-1:0][TAG_W-1:0] wr_tag;
    logic [DEPTH-1:0][TAG_W-1:0] tag_arr;
    logic [DEPTH-1:0]            br_arr, exc_arr, done_arr;

    assign head_idx = head_q[IDX_W-1:0];
    assign tail_idx = tail_q[IDX_W-1:0];
    assign count    = tail_q - head_q;
    assign free_cnt = PTR_W'(DEPTH) - count;
    assign dcnt_ext = PTR_W'(disp_cnt_i);
    assign nret_ext = PTR_W'(nret);

    // Age of a reported entry relative to the head; occupied if below count.
    assign mp_off   = mp_idx_i - head_idx;
    assign fin_off  = fin_idx_i - head_idx;
    assign mp_hit   = run && mp_valid_i && (PTR_W'(mp_off) < count) && br_arr[mp_idx_i];
    assign fin_set  = fin_valid_i && (PTR_W'(fin_off) < count);
    assign exc_head = (count != '0) && exc_arr[head_idx];

    assign disp_grant_o = run && !mp_hit && (disp_cnt_i <= CNT_W'(LANES))
                          && (dcnt_ext <= free_cnt);
    assign disp_idx_o   = tail_idx;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign wr_en[l]  = disp_grant_o && (dcnt_ext > PTR_W'(l));
        assign wr_idx[l] = tail_idx + IDX_W'(l);
        assign wr_tag[l] = disp_tag_i[l*TAG_W +: TAG_W];
        assign ret_tag_o[l*TAG_W +: TAG_W] = tag_arr[head_idx + IDX_W'(l)];
    end

    assign ret_valid_o = ret_en;
    assign exc_valid_o = raise;
    assign exc_tag_o   = raise ? tag_arr[head_idx] : '0;

    rob_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .exc_head_i (exc_head),
        .run_o      (run),
        .raise_o    (raise)
    );

    rob_store #(
        .DEPTH (DEPTH),
        .TAG_W (TAG_W),
        .LANES (LANES)
    ) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_tag   (wr_tag),
        .wr_br    (disp_br_i),
        .wr_exc   (disp_exc_i),
        .fin_set  (fin_set),
        .fin_idx  (fin_idx_i),
        .tag_arr  (tag_arr),
        .br_arr   (br_arr),
        .exc_arr  (exc_arr),
        .done_arr (done_arr)
    );

    rob_retire_sel #(
        .DEPTH (DEPTH),
        .LANES (LANES)
    ) u_sel (
        .run      (run),
        .count    (count),
        .head_idx (head_idx),
        .done_arr (done_arr),
        .exc_arr  (exc_arr),
        .mp_hit   (mp_hit),
        .mp_off   (mp_off),
        .ret_en   (ret_en),
        .nret     (nret)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q <= '0;
            tail_q <= '0;
        end else if (raise) begin
            // Leaving RAISE empties the queue at the excepting entry.
            tail_q <= head_q;
        end else begin
            head_q <= head_q + nret_ext;
            if (mp_hit) begin
                tail_q <= head_q + PTR_W'(mp_off) + PTR_W'(1);
            end else if (disp_grant_o) begin
                tail_q <= tail_q + dcnt_ext;
            end
        end
    end

endmodule

// File: rtl/completion_rob_chk.sv
module completion_rob_chk #(
    parameter int DEPTH = 8,
    parameter int LANES = 2,
    parameter int IDX_W = 3,
    parameter int PTR_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic [PTR_W-1:0] count,
    input logic [IDX_W-1:0] head_idx,
    input logic [DEPTH-1:0] done_arr,
    input logic [LANES-1:0] ret_valid_o,
    input logic             exc_valid_o,
    input logic             mp_hit,
    input logic [IDX_W-1:0] mp_off
);

    assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        count <= PTR_W'(DEPTH));

    assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (count <= $past(count) + PTR_W'(LANES)));

    assert_slot_order_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ret_valid_o[1] |-> ret_valid_o[0]);

    assert_head_blocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((count == '0) || !done_arr[head_idx]) |-> (ret_valid_o == '0));

    assert_mp_trims_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mp_hit |=> (count <= $past(PTR_W'(mp_off)) + PTR_W'(1)));

    assert_exc_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        exc_valid_o |=> !exc_valid_o);

    assert_exc_no_retire_R10: assert property (@(posedge clk) disable iff (!rst_n)
        exc_valid_o |-> (ret_valid_o == '0));

    assert_exc_empties_R10: assert property (@(posedge clk) disable iff (!rst_n)
        exc_valid_o |=> (count == '0));

endmodule

bind completion_rob completion_rob_chk #(
    .DEPTH (DEPTH),
    .LANES (LANES),
    .IDX_W (IDX_W),
    .PTR_W (PTR_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .count       (count),
    .head_idx    (head_idx),
    .done_arr    (done_arr),
    .ret_valid_o (ret_valid_o),
    .exc_valid_o (exc_valid_o),
    .mp_hit      (mp_hit),
    .mp_off      (mp_off)
);

// File: tb/test_completion_rob.sv
module test_completion_rob;

    localparam int DEPTH = 8;
    localparam int TAG_W = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  disp_cnt_i;
    logic [15:0] disp_tag_i;
    logic [1:0]  disp_br_i, disp_exc_i;
    logic        disp_grant_o;
    logic [2:0]  disp_idx_o;
    logic        fin_valid_i;
    logic [2:0]  fin_idx_i;
    logic        mp_valid_i;
    logic [2:0]  mp_idx_i;
    logic [1:0]  ret_valid_o;
    logic [15:0] ret_tag_o;
    logic        exc_valid_o;
    logic [7:0]  exc_tag_o;

    always #4 clk = ~clk;  // 125 MHz

    completion_rob #(.DEPTH(DEPTH), .TAG_W(TAG_W)) i_completion_rob (
        .clk(clk), .rst_n(rst_n),
        .disp_cnt_i(disp_cnt_i), .disp_tag_i(disp_tag_i), .disp_br_i(disp_br_i),
        .disp_exc_i(disp_exc_i), .disp_grant_o(disp_grant_o), .disp_idx_o(disp_idx_o),
        .fin_valid_i(fin_valid_i), .fin_idx_i(fin_idx_i),
        .mp_valid_i(mp_valid_i), .mp_idx_i(mp_idx_i),
        .ret_valid_o(ret_valid_o), .ret_tag_o(ret_tag_o),
        .exc_valid_o(exc_valid_o), .exc_tag_o(exc_tag_o)
    );

    typedef struct {int tag; bit br; bit exc; bit done;} ent_t;
    ent_t  q[$];
    int    head_m;
    bit    raise_m;
    int    n_cmp, n_bad;
    bit    finished;
    string scn;

    task automatic cmp(string what, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL [%s] %s: actual %0h expected %0h", scn, what, act, exp);
        end
    endtask

    // Reference model: expected outputs from current state and inputs, then the clock edge.
    task automatic model_step();
        int  cnt, off_mp, off_f, dc, nret;
        bit  mp_hit, exc_det, grant, r0, r1, run;
        ent_t e;
        cnt    = q.size();
        run    = !raise_m;
        dc     = int'(disp_cnt_i);
        off_mp = (int'(mp_idx_i) - head_m + DEPTH) % DEPTH;
        off_f  = (int'(fin_idx_i) - head_m + DEPTH) % DEPTH;
        mp_hit = run && mp_valid_i && (off_mp < cnt) && q[off_mp].br;
        exc_det = run && (cnt > 0) && q[0].exc;
        grant  = run && !mp_hit && (dc <= 2) && (dc <= DEPTH - cnt);
        r0 = run && (cnt > 0) && q[0].done && !q[0].exc;
        r1 = r0 && (cnt > 1) && q[1].done && !q[1].exc && !(mp_hit && off_mp < 1);
        nret = int'(r0) + int'(r1);

        cmp("R2 dispatch grant", 32'(disp_grant_o), 32'(grant));
        cmp("R3 dispatch index", 32'(disp_idx_o), 32'((head_m + cnt) % DEPTH));
        cmp("R5 retire valid", 32'(ret_valid_o), 32'({r1, r0}));
        if (r0) cmp("R6 retire tag slot0", 32'(ret_tag_o[7:0]), 32'(q[0].tag));
        if (r1) cmp("R6 retire tag slot1", 32'(ret_tag_o[15:8]), 32'(q[1].tag));
        cmp("R10 exception valid", 32'(exc_valid_o), 32'(raise_m));
        if (raise_m) cmp("R10 exception tag", 32'(exc_tag_o), 32'(q[0].tag));

        if (raise_m) begin
            q.delete();
            raise_m = 1'b0;
        end else begin
            if (fin_valid_i && off_f < cnt) q[off_f].done = 1'b1;
            if (mp_hit) q = q[0:off_mp];
            repeat (nret) void'(q.pop_front());
            head_m = (head_m + nret) % DEPTH;
            if (grant) begin
                for (int l = 0; l < dc; l++) begin
                    e.tag = int'(disp_tag_i[l*8 +: 8]);
                    e.br = disp_br_i[l];
                    e.exc = disp_exc_i[l];
                    e.done = 1'b0;
                    q.push_back(e);
                end
            end
            raise_m = exc_det;
        end
    endtask

    task automatic drive(int dc, int t0, int t1, bit [1:0] br, bit [1:0] ex,
                         bit fv, int fi, bit mv, int mi);
        disp_cnt_i  = 2'(dc);
        disp_tag_i  = {8'(t1), 8'(t0)};
        disp_br_i   = br;
        disp_exc_i  = ex;
        fin_valid_i = fv;
        fin_idx_i   = 3'(fi);
        mp_valid_i  = mv;
        mp_idx_i    = 3'(mi);
    endtask

    task automatic idle();
        drive(0, 0, 0, 2'b00, 2'b00, 1'b0, 0, 1'b0, 0);
    endtask

    task automatic go();
        #2;
        model_step();
        @(negedge clk);
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        #(8 * 100000);
        if (!finished) begin
            n_bad++;
            $display("FAIL [watchdog] run did not complete: actual hung expected done");
            summary();
            $finish;
        end
    end

    initial begin
        int tagc;
        idle();
        head_m = 0; raise_m = 1'b0; n_cmp = 0; n_bad = 0; finished = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        scn = "R1 reset";
        drive(2, 0, 0, 2'b00, 2'b00, 1'b0, 0, 1'b0, 0);
        #1;
        cmp("R1 no retire", 32'(ret_valid_o), 32'd0);
        cmp("R1 no exception", 32'(exc_valid_o), 32'd0);
        cmp("R1 index zero", 32'(disp_idx_o), 32'd0);
        cmp("R1 two granted", 32'(disp_grant_o), 32'd1);
        idle(); go();

        // R2 / R3: fill to eight entries, then refuse one more
        scn = "R2 fill";
        for (int i = 0; i < 4; i++) begin
            drive(2, 16 + 2*i, 17 + 2*i, 2'b00, 2'b00, 1'b0, 0, 1'b0, 0);
            go();
        end
        drive(1, 99, 0, 2'b00, 2'b00, 1'b0, 0, 1'b0, 0);
        #1;
        cmp("R2 full refuses", 32'(disp_grant_o), 32'd0);
        go();

        // R5 / R7: younger done does not pass an undone head
        scn = "R5 order";
        drive(0, 0, 0, 2'b00, 2'b00, 1'b1, 1, 1'b0, 0); go();
        idle(); #1;
        cmp("R5 younger waits", 32'(ret_valid_o), 32'd0);
        go();
        drive(0, 0, 0, 2'b00, 2'b00, 1'b1, 0, 1'b0, 0); go();
        idle(); #1;
        cmp("R7 pair retires next cycle", 32'(ret_valid_o), 32'd3);
        go();
        for (int i = 2; i < 8; i++) begin
            drive(0, 0, 0, 2'b00, 2'b00, 1'b1, i, 1'b0, 0); go();
        end
        repeat (4) begin idle(); go(); end

        // R4: report for an empty entry is ignored
        scn = "R4 empty report";
        drive(0, 0, 0, 2'b00, 2'b00, 1'b1, 1, 1'b0, 0); go();
        drive(2, 40, 41, 2'b00, 2'b00, 1'b0, 0, 1'b0, 0); go();
        drive(0, 0, 0, 2'b00, 2'b00, 1'b1, 0, 1'b0, 0); go();
        idle(); #1;
        cmp("R4 only reported entry retires", 32'(ret_valid_o), 32'd1);
        go();
        drive(0, 0, 0, 2'b00, 2'b00, 1'b1, 1, 1'b0, 0); go();
        repeat (2) begin idle(); go(); end

        // R8: mispredict at index 2 flushes younger entries
        scn = "R8 mispredict";
        drive(2, 50, 51, 2'b01, 2'b00, 1'b0, 0, 1'b0, 0); go();
        drive(2, 52, 53, 2'b00, 2'b00, 1'b0, 0, 1'b0, 0); go();
        drive(0, 0, 0, 2'b00, 2'b00, 1'b1, 3, 1'b0, 0); go();
        drive(0, 0, 0, 2'b00, 2'b00, 1'b1, 2, 1'b1, 2); go();
        idle(); #1;
        cmp("R8 tail after flush", 32'(disp_idx_o), 32'd3);
        cmp("R8 branch retires alone", 32'(ret_valid_o), 32'd1);
        go();
        idle(); go();

        // R9: mispredict on a non-branch or empty entry is ignored
        scn = "R9 ignored mispredict";
        drive(2, 60, 61, 2'b00, 2'b00, 1'b0, 0, 1'b0, 0); go();
        drive(0, 0, 0, 2'b00, 2'b00, 1'b0, 0, 1'b1, 3); go();
        idle(); #1;
        cmp("R9 non-branch keeps tail", 32'(disp_idx_o), 32'd5);
        go();
        drive(0, 0, 0, 2'b00, 2'b00, 1'b0, 0, 1'b1, 6); go();
        idle(); #1;
        cmp("R9 empty keeps tail", 32'(disp_idx_o), 32'd5);
        go();
        drive(0, 0, 0, 2'b00, 2'b00, 1'b1, 3, 1'b0, 0); go();
        drive(0, 0, 0, 2'b00, 2'b00, 1'b1, 4, 1'b0, 0); go();
        repeat (2) begin idle(); go(); end

        // R10: exception at the head
        scn = "R10 exception";
        drive(2, 229, 70, 2'b00, 2'b01, 1'b0, 0, 1'b0, 0); go();
        drive(0, 0, 0, 2'b00, 2'b00, 1'b1, 6, 1'b0, 0); #1;
        cmp("R10 head blocks retire", 32'(ret_valid_o), 32'd0);
        go();
        idle(); #1;
        cmp("R10 pulse", 32'(exc_valid_o), 32'd1);
        cmp("R10 pulse tag", 32'(exc_tag_o), 32'd229);
        go();
        idle(); #1;
        cmp("R10 pulse ends", 32'(exc_valid_o), 32'd0);
        cmp("R10 empty at excepting index", 32'(disp_idx_o), 32'd5);
        go();

        // Mixed traffic checked cycle by cycle against the model
        scn = "R2-mix traffic";
        tagc = 1;
        for (int c = 0; c < 4000; c++) begin
            int dc, fi, mi;
            bit fv, mv;
            bit [1:0] br, ex;
            dc = $urandom_range(0, 9);
            dc = (dc < 3) ? 0 : (dc < 6) ? 1 : (dc < 9) ? 2 : 3;
            br = {($urandom_range(0, 3) == 0), ($urandom_range(0, 3) == 0)};
            ex = {($urandom_range(0, 40) == 0), ($urandom_range(0, 40) == 0)};
            fv = ($urandom_range(0, 9) < 7);
            fi = $urandom_range(0, 7);
            mv = ($urandom_range(0, 11) == 0);
            mi = $urandom_range(0, 7);
            drive(dc, tagc % 256, (tagc + 1) % 256, br, ex, fv, fi, mv, mi);
            tagc += 2;
            go();
        end
        repeat (4) begin idle(); go(); end

        finished = 1'b1;
        summary();
        $finish;
    end

endmodule